// File: doc/BRIEF.md
# Windowed Fine Timing Search

This block refines a coarse estimate of where a synchronization sequence starts in a buffered stream of complex samples. A start strobe hands it the coarse position and the choice of local reference sequence. The block then tries every start point in a window centred on that position, at the full sample rate. Each trial point is treated as the first sample of the sequence, and the block forms the full-length complex correlation of the buffered samples against the chosen local reference.

For each trial it takes the squared magnitude of the correlation as a metric. It keeps the trial with the largest metric and reports that sample index together with its metric.

The block reads its samples through a synchronous read port into an external sample buffer. It reads the local references through a second synchronous read port into an external reference store, which holds one bank per reference. The block does not fill the buffer, decimate the stream or correct for frequency.

Top module: `fine_timing_search`

## Requirements
- R1: After reset, busy, done, fine_pos and fine_metric are all zero.
- R2: A start seen while busy is low sets busy at that clock edge. Busy stays high until the edge that raises done. Done is a single-cycle pulse that comes exactly NCAND*SEQ_LEN+3 = 4675 clock edges after the start edge, and busy falls at that same edge.
- R3: The trial positions are base+k for k = 0..72, in increasing k, where base = coarse_pos-36. In the k-th trial's n-th cycle, samp_addr is base+k+n. fine_pos is always one of the trial positions.
- R4: The metric of trial position c is |sum over n = 0..63 of x[c+n]*conj(r[n])|^2, computed exactly with no truncation. Here x is the sample buffer, r is the selected reference, and both ports return data one cycle after the address. fine_metric is the metric of the position given in fine_pos.
- R5: The reported trial has the largest metric. When metrics are equal, the trial visited first (lowest k) is kept.
- R6: ref_addr carries the latched reference select in bits [7:6] and the sequence index n in bits [5:0].
- R7: A start that arrives while busy is high is ignored. It changes neither the completion time nor the result.
- R8: Sample addresses and fine_pos wrap modulo 2^AW.
- R9: fine_pos and fine_metric change only at the edge that raises done, and they hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a search |
| coarse_pos | input | AW | Coarse start position (window centre) |
| root_sel | input | RW | Local reference bank select |
| samp_addr | output | AW | Sample buffer read address |
| samp_re | input | W | Sample real part, one cycle after address |
| samp_im | input | W | Sample imaginary part |
| ref_addr | output | RW+NW | Reference store read address {bank, index} |
| ref_re | input | W | Reference real part, one cycle after address |
| ref_im | input | W | Reference imaginary part |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| fine_pos | output | AW | Refined start index |
| fine_metric | output | MW | Squared correlation magnitude at fine_pos |

## Verification
A wrong trial or sequence counter shows at the ports within a few cycles of start. It puts samp_addr or ref_addr off their expected values, and the bench samples those early in each run. A corrupted accumulator, metric or best-trial register only shows when done rises, as a fine_pos or fine_metric that differs from the bench's own exhaustive correlation. The bench sweeps all references, several window centres, a wrapped window and an all-equal window so that such faults land on a compared value. A faulty busy or done sequence shows as a completion edge count that is not 4675.

// File: rtl/fine_timing_search.sv
module fine_timing_search #(
  parameter int W       = 12,
  parameter int AW      = 12,
  parameter int SEQ_LEN = 64,
  parameter int HALF    = 36,
  parameter int NROOT   = 3,
  localparam int NCAND  = 2*HALF+1,
  localparam int NW     = $clog2(SEQ_LEN),
  localparam int KW     = $clog2(NCAND),
  localparam int RW     = (NROOT > 1) ? $clog2(NROOT) : 1,
  localparam int PW     = 2*W+1,
  localparam int ACCW   = PW+NW,
  localparam int MW     = 2*ACCW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        coarse_pos,
  input  logic [RW-1:0]        root_sel,
  output logic [AW-1:0]        samp_addr,
  input  logic signed [W-1:0]  samp_re,
  input  logic signed [W-1:0]  samp_im,
  output logic [RW+NW-1:0]     ref_addr,
  input  logic signed [W-1:0]  ref_re,
  input  logic signed [W-1:0]  ref_im,
  output logic                 busy,
  output logic                 done,
  output logic [AW-1:0]        fine_pos,
  output logic [MW-1:0]        fine_metric
);
  localparam logic [AW-1:0] HALF_A = AW'(HALF);
  localparam logic [NW-1:0] NLAST  = NW'(SEQ_LEN-1);
  localparam logic [KW-1:0] KLAST  = KW'(NCAND-1);

  logic              run;
  logic [KW-1:0]     k, k1, a_k, m_k, best_k;
  logic [NW-1:0]     n;
  logic [AW-1:0]     base_q;
  logic [RW-1:0]     root_q;
  logic              v1, f1, l1, a_v, m_v;
  logic signed [ACCW-1:0] acc_re, acc_im;
  logic [MW-1:0]     metric, best_m;

  wire go = start & ~busy;

  assign samp_addr = base_q + AW'(k) + AW'(n);
  assign ref_addr  = {root_q, n};

  logic signed [PW-1:0] xr, xi, rr, ri, pr_re, pr_im;
  assign xr = PW'(samp_re);
  assign xi = PW'(samp_im);
  assign rr = PW'(ref_re);
  assign ri = PW'(ref_im);
  assign pr_re = xr*rr + xi*ri;
  assign pr_im = xi*rr - xr*ri;

  logic signed [MW-1:0] sq_re, sq_im;
  logic [MW-1:0] mag;
  assign sq_re = MW'(acc_re) * MW'(acc_re);
  assign sq_im = MW'(acc_im) * MW'(acc_im);
  assign mag   = $unsigned(sq_re + sq_im);

  wire take = (m_k == '0) || (metric > best_m);
  wire fin  = m_v && (m_k == KLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; run <= 1'b0; k <= '0; n <= '0;
      base_q <= '0; root_q <= '0;
    end else if (go) begin
      busy <= 1'b1; run <= 1'b1; k <= '0; n <= '0;
      base_q <= coarse_pos - HALF_A;
      root_q <= root_sel;
    end else begin
      if (fin) busy <= 1'b0;
      if (run) begin
        if (n == NLAST) begin
          n <= '0;
          if (k == KLAST) run <= 1'b0;
          else            k <= k + 1'b1;
        end else begin
          n <= n + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; f1 <= 1'b0; l1 <= 1'b0; k1 <= '0;
      acc_re <= '0; acc_im <= '0; a_v <= 1'b0; a_k <= '0;
      m_v <= 1'b0; m_k <= '0; metric <= '0;
      best_k <= '0; best_m <= '0;
      done <= 1'b0; fine_pos <= '0; fine_metric <= '0;
    end else begin
      v1 <= run;
      f1 <= (n == '0);
      l1 <= (n == NLAST);
      k1 <= k;
      if (v1) begin
        acc_re <= (f1 ? '0 : acc_re) + ACCW'(pr_re);
        acc_im <= (f1 ? '0 : acc_im) + ACCW'(pr_im);
      end
      a_v <= v1 && l1;
      a_k <= k1;
      m_v <= a_v;
      m_k <= a_k;
      if (a_v) metric <= mag;
      if (m_v && take) begin
        best_k <= m_k;
        best_m <= metric;
      end
      done <= fin;
      if (fin) begin
        fine_pos    <= base_q + AW'(take ? m_k : best_k);
        fine_metric <= take ? metric : best_m;
      end
    end
  end
endmodule

// File: rtl/fine_timing_search_chk.sv
module fine_timing_search_chk #(
  parameter int AW   = 12,
  parameter int MW   = 62,
  parameter int SPAN = 136
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          run,
  input logic [AW-1:0] samp_addr,
  input logic [AW-1:0] base,
  input logic [AW-1:0] fine_pos,
  input logic [MW-1:0] fine_metric
);
  logic [AW-1:0] rel;
  assign rel = samp_addr - base;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R2
  AST_BUSY_FALLS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R2
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) run |-> (rel <= AW'(SPAN-1))); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(fine_pos) && $stable(fine_metric))); // R9
endmodule

bind fine_timing_search fine_timing_search_chk #(.AW(AW), .MW(MW), .SPAN(NCAND+SEQ_LEN-1)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .run(run),
  .samp_addr(samp_addr), .base(base_q), .fine_pos(fine_pos), .fine_metric(fine_metric)
);

// File: tb/fine_timing_search_bench.sv
module fine_timing_search_bench;
  localparam int W = 12, AW = 12, SEQ = 64, HALF = 36, NC = 73, MW = 62;
  localparam int DEPTH = 4096;
  localparam int LAT = NC*SEQ + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] coarse_pos = '0;
  logic [1:0] root_sel = '0;
  logic [AW-1:0] samp_addr;
  logic signed [W-1:0] samp_re, samp_im, ref_re, ref_im;
  logic [7:0] ref_addr;
  logic busy, done;
  logic [AW-1:0] fine_pos;
  logic [MW-1:0] fine_metric;

  int mem_re [DEPTH];
  int mem_im [DEPTH];
  int rf_re [256];
  int rf_im [256];
  int unsigned st = 32'h1234_5678;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  fine_timing_search u_fine_timing_search (
    .clk(clk), .rst_n(rst_n), .start(start), .coarse_pos(coarse_pos), .root_sel(root_sel),
    .samp_addr(samp_addr), .samp_re(samp_re), .samp_im(samp_im),
    .ref_addr(ref_addr), .ref_re(ref_re), .ref_im(ref_im),
    .busy(busy), .done(done), .fine_pos(fine_pos), .fine_metric(fine_metric)
  );

  always @(posedge clk) begin
    samp_re <= W'(mem_re[samp_addr]);
    samp_im <= W'(mem_im[samp_addr]);
    ref_re  <= W'(rf_re[ref_addr]);
    ref_im  <= W'(rf_im[ref_addr]);
  end

  function automatic int prn(int amp);
    st = st * 32'd1103515245 + 32'd12345;
    return int'((st >> 16) % (2*amp+1)) - amp;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint metric_at(int c, int root);
    longint ar = 0, ai = 0;
    for (int i = 0; i < SEQ; i++) begin
      longint xr = mem_re[(c+i) % DEPTH], xi = mem_im[(c+i) % DEPTH];
      longint rr = rf_re[root*64+i], ri = rf_im[root*64+i];
      ar += xr*rr + xi*ri;
      ai += xi*rr - xr*ri;
    end
    return ar*ar + ai*ai;
  endfunction

  task automatic fill_noise(int amp);
    for (int i = 0; i < DEPTH; i++) begin
      mem_re[i] = prn(amp);
      mem_im[i] = prn(amp);
    end
  endtask

  task automatic plant(int pos, int root);
    for (int i = 0; i < SEQ; i++) begin
      mem_re[(pos+i) % DEPTH] += rf_re[root*64+i];
      mem_im[(pos+i) % DEPTH] += rf_im[root*64+i];
    end
  endtask

  task automatic search(int coarse, int root, bit inject);
    int base, cnt, bk;
    longint bm;
    base = (coarse - HALF + DEPTH) % DEPTH;
    bk = 0; bm = 0;
    for (int k = 0; k < NC; k++) begin
      longint m = metric_at((base + k) % DEPTH, root);
      if (k == 0 || m > bm) begin bm = m; bk = k; end
    end
    @(negedge clk);
    coarse_pos = AW'(coarse);
    root_sel = 2'(root);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    chk("R2 busy after start", longint'(busy), 1);
    while (!done && cnt < LAT + 50) begin
      if (cnt == 3) begin
        chk("R6 ref_addr bank/index", longint'(ref_addr), root*64 + 3);
        chk("R3/R8 samp_addr", longint'(samp_addr), (base + 3) % DEPTH);
      end
      if (cnt == 2000) chk("R2 busy held", longint'(busy), 1);
      if (inject && cnt == 100) begin
        coarse_pos = AW'(coarse + 500);
        root_sel = 2'((root + 1) % 3);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk(inject ? "R7 latency with ignored start" : "R2 done latency", cnt, LAT);
    chk("R2 busy low at done", longint'(busy), 0);
    chk(inject ? "R7 fine_pos unchanged by late start" : "R3/R5 fine_pos", longint'(fine_pos), (base + bk) % DEPTH);
    chk("R4/R5 fine_metric", longint'(fine_metric), bm);
    @(negedge clk);
    chk("R2 done single pulse", longint'(done), 0);
    repeat (3) @(negedge clk);
    chk("R9 fine_pos held", longint'(fine_pos), (base + bk) % DEPTH);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL R2 watchdog actual=no_done expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      rf_re[i] = prn(100);
      rf_im[i] = prn(100);
    end
    for (int i = 0; i < DEPTH; i++) begin mem_re[i] = 0; mem_im[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 busy reset", longint'(busy), 0);
    chk("R1 done reset", longint'(done), 0);
    chk("R1 fine_pos reset", longint'(fine_pos), 0);
    chk("R1 fine_metric reset", longint'(fine_metric), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", longint'(busy), 0);

    // R5: all-zero buffer, every metric ties at zero; first trial wins
    search(1000, 0, 1'b0);
    chk("R5 tie picks lowest offset", longint'(fine_pos), 1000 - HALF);

    // R4/R5 sweep of references and planted offsets
    for (int r = 0; r < 3; r++) begin
      for (int j = 0; j < 3; j++) begin
        int c = 600 + 1100*j;
        int off = (j == 0) ? -HALF : ((j == 1) ? 7 : HALF);
        fill_noise(20);
        plant(c + off, r);
        search(c, r, 1'b0);
      end
    end

    // R5: two identical copies in window, earlier one kept on tie
    for (int i = 0; i < DEPTH; i++) begin mem_re[i] = 0; mem_im[i] = 0; end
    plant(2000 - HALF + 5, 1);
    plant(2000 - HALF + 5 + SEQ + 2, 1);
    search(2000, 1, 1'b0);
    chk("R5 equal peaks keep first", longint'(fine_pos), 2000 - HALF + 5);

    // R8: window and sequence wrap past the end of the buffer
    fill_noise(20);
    plant(4090, 2);
    search(10, 2, 1'b0);
    chk("R8 wrapped peak position", longint'(fine_pos), 4090);

    // R7: start pulsed mid-search is ignored
    fill_noise(20);
    plant(1500 + 3, 0);
    search(1500, 0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule